// File: doc/BRIEF.md
# Serial Three-Wire EEPROM Target

This block is a synthesizable, clock-synchronous model of a small serial EEPROM with three wires. It holds 2048 bits in an internal register array. A strap input arranges the array either as 256 bytes or as 128 sixteen-bit words. A host drives chip select, a serial clock and a data line. The block shifts in a start bit, a two-bit opcode, an address field and, where the command needs it, a data field. It answers on a serial output that has its own output-enable.

Reads return a zero marker bit and then the stored data. The data streams on through consecutive addresses for as long as chip select stays high. Programming commands are guarded by an enable latch. They are launched when chip select falls, and they run for a programmable number of system clocks. During that time the output reports busy or ready whenever chip select is high.

All three serial pins are oversampled by the system clock. The serial clock therefore has to be several system clocks long in each phase.

Top module: `mw_eeprom`

## Requirements
- R1: An instruction starts at the first serial-clock rising edge, with chip select high, that samples a 1 on the data input. Zeros sampled before that edge are ignored.
- R2: The opcode that follows the start bit selects the command: 10 read, 01 write, 11 erase. With opcode 00, the top two bits of the address field select a further command: 11 enable, 00 disable, 10 erase-all, 01 write-all.
- R3: With the strap high (word mode) the address field is 8 bits: a don't-care bit and a 7-bit word address. With the strap low (byte mode) it is 9 bits: a don't-care bit and an 8-bit byte address. Word w occupies bytes 2w (upper half) and 2w+1 (lower half).
- R4: Enable, disable, erase and erase-all need exactly 12 serial clocks in byte mode and 11 in word mode. Write and write-all need exactly 20 in byte mode and 27 in word mode. Any other count at the fall of chip select does nothing.
- R5: A read drives a 0 on the rising edge that takes the last address bit. Each following rising edge drives the next data bit, most significant bit first. The address then advances and wraps at the end of the array, until chip select falls.
- R6: After reset programming is disabled. The enable command sets the enable latch and the disable command clears it. Write, write-all, erase and erase-all start only while the latch is set.
- R7: A valid programming command starts a busy period of PROG_CYCLES system clocks at the fall of chip select. While chip select is high, the output is enabled and reads 0 while busy and 1 once ready.
- R8: Erase sets the addressed unit to all ones and erase-all sets the whole array to all ones. Write and write-all leave exactly the supplied data in their targets.
- R9: The output-enable is low whenever chip select is low, and it stays low during and after enable and disable commands.
- R10: Serial traffic during a busy period has no effect: the enable latch and the array stay unchanged.
- R11: A fall of chip select discards any partly received instruction, so the next start bit begins a fresh instruction.
- R12: After reset every array byte reads 0xFF and the output-enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data into the block |
| org16 | input | 1 | Organization strap: 1 for 16-bit words, 0 for bytes |
| sdo | output | 1 | Serial data out, or the ready/busy status |
| sdo_oe | output | 1 | Output-enable for sdo (0 means high impedance) |

## Verification
A wrong bit count or a misdecoded opcode first shows up at the next chip-select fall. No busy status appears, or a busy period appears where none should. The bench probes this by raising chip select a few clocks later. Corrupted array contents or a bad read pointer show up only when the affected address is read back. The marker bit and the word boundaries of a continuous stream therefore expose an off-by-one within one word time. A stuck enable latch or a busy state that leaks into decoding shows up as a missing or extra programming cycle on the very next command.

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
  parameter int PROG_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sclk,
  input  logic sdi,
  input  logic org16,
  output logic sdo,
  output logic sdo_oe
);
  localparam int NBYTES = 256;
  localparam int SR_W   = 32;
  localparam int PW     = $clog2(PROG_CYCLES + 1);

  localparam logic [1:0] OP_EXT = 2'b00, OP_WRITE = 2'b01, OP_READ = 2'b10, OP_ERASE = 2'b11;
  localparam logic [1:0] SUB_WDS = 2'b00, SUB_WRAL = 2'b01, SUB_ERAL = 2'b10, SUB_WEN = 2'b11;
  localparam logic [1:0] K_ERASE = 2'd0, K_ERAL = 2'd1, K_WRITE = 2'd2, K_WRAL = 2'd3;

  logic [7:0] mem [NBYTES];

  logic cs_m, cs_s, cs_d, sk_m, sk_s, sk_d, di_m, di_s, org_m, org_s;
  logic [4:0] cnt;
  logic [SR_W-1:0] sr;
  logic wel, busy, stat;
  logic [PW-1:0] pcnt;
  logic [1:0] p_kind;
  logic [7:0] p_addr;
  logic [15:0] p_data;
  logic p_org;
  logic rd_active, rd_q;
  logic [7:0] rd_addr;
  logic [3:0] rd_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {cs_m, cs_s, cs_d, sk_m, sk_s, sk_d, di_m, di_s, org_m, org_s} <= '0;
    end else begin
      cs_m <= cs;    cs_s <= cs_m;   cs_d <= cs_s;
      sk_m <= sclk;  sk_s <= sk_m;   sk_d <= sk_s;
      di_m <= sdi;   di_s <= di_m;
      org_m <= org16; org_s <= org_m;
    end
  end

  wire sk_rise = sk_s & ~sk_d & cs_s;
  wire cs_fall = cs_d & ~cs_s;

  wire [4:0] hdr_len  = org_s ? 5'd11 : 5'd12;
  wire [4:0] full_len = org_s ? 5'd27 : 5'd20;
  wire [4:0] dlen     = org_s ? 5'd16 : 5'd8;
  wire [4:0] af       = org_s ? 5'd8  : 5'd9;
  wire [4:0] afm2     = af - 5'd2;

  wire [SR_W-1:0] sr_nx = {sr[SR_W-2:0], di_s};
  wire start_bit = sk_rise && !busy && cnt == 5'd0 && di_s;
  wire rd_start  = sk_rise && !busy && cnt == hdr_len - 5'd1 && sr_nx[af +: 2] == OP_READ;

  wire hdr_match  = cnt == hdr_len;
  wire full_match = cnt == full_len;
  wire [SR_W-1:0] hv = full_match ? (sr >> dlen) : sr;
  wire [1:0] op_f  = hv[af +: 2];
  wire [1:0] sub_f = hv[afm2 +: 2];
  wire [7:0] addr_f = org_s ? {1'b0, hv[6:0]} : hv[7:0];
  wire [15:0] data_f = org_s ? sr[15:0] : {8'h00, sr[7:0]};

  wire act = cs_fall && !busy && !rd_active;
  wire is_ext = op_f == OP_EXT;
  wire do_wen   = act && hdr_match && is_ext && sub_f == SUB_WEN;
  wire do_wds   = act && hdr_match && is_ext && sub_f == SUB_WDS;
  wire do_erase = hdr_match && op_f == OP_ERASE;
  wire do_eral  = hdr_match && is_ext && sub_f == SUB_ERAL;
  wire do_write = full_match && op_f == OP_WRITE;
  wire do_wral  = full_match && is_ext && sub_f == SUB_WRAL;
  wire do_prog  = act && wel && (do_erase || do_eral || do_write || do_wral);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sr  <= '0;
    end else if (cs_fall) begin
      cnt <= '0;
      sr  <= '0;
    end else if (sk_rise && !busy) begin
      if (cnt == 5'd0) begin
        if (di_s) cnt <= 5'd1;
        sr <= '0;
      end else begin
        sr  <= sr_nx;
        cnt <= (cnt == 5'd31) ? cnt : cnt + 5'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wel <= 1'b0;
    else if (do_wen) wel <= 1'b1;
    else if (do_wds) wel <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      pcnt <= '0;
      p_kind <= K_ERASE;
      p_addr <= '0;
      p_data <= '0;
      p_org <= 1'b0;
    end else if (do_prog) begin
      busy <= 1'b1;
      pcnt <= PW'(PROG_CYCLES);
      p_kind <= do_erase ? K_ERASE : do_eral ? K_ERAL : do_write ? K_WRITE : K_WRAL;
      p_addr <= addr_f;
      p_data <= data_f;
      p_org <= org_s;
    end else if (busy) begin
      pcnt <= pcnt - PW'(1);
      if (pcnt == PW'(1)) busy <= 1'b0;
    end
  end

  wire commit = busy && pcnt == PW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBYTES; i++) mem[i] <= 8'hFF;
    end else if (commit) begin
      for (int i = 0; i < NBYTES; i++) begin
        case (p_kind)
          K_ERAL:  mem[i] <= 8'hFF;
          K_WRAL:  mem[i] <= (p_org && i % 2 == 0) ? p_data[15:8] : p_data[7:0];
          K_ERASE: if (p_org ? (i / 2 == int'(p_addr[6:0])) : (i == int'(p_addr))) mem[i] <= 8'hFF;
          default: if (p_org ? (i / 2 == int'(p_addr[6:0])) : (i == int'(p_addr)))
                     mem[i] <= (p_org && i % 2 == 0) ? p_data[15:8] : p_data[7:0];
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= 1'b0;
    else if (do_prog) stat <= 1'b1;
    else if ((!busy && !cs_s) || start_bit) stat <= 1'b0;
  end

  wire [15:0] rd_word = org_s ? {mem[{rd_addr[6:0], 1'b0}], mem[{rd_addr[6:0], 1'b1}]}
                              : {mem[rd_addr], 8'h00};
  wire rd_last = {1'b0, rd_bit} == dlen - 5'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_active <= 1'b0;
      rd_q <= 1'b0;
      rd_addr <= '0;
      rd_bit <= '0;
    end else if (cs_fall) begin
      rd_active <= 1'b0;
    end else if (rd_start) begin
      rd_active <= 1'b1;
      rd_q <= 1'b0;
      rd_addr <= org_s ? {1'b0, sr_nx[6:0]} : sr_nx[7:0];
      rd_bit <= '0;
    end else if (rd_active && sk_rise) begin
      rd_q <= rd_word[4'd15 - rd_bit];
      if (rd_last) begin
        rd_bit <= '0;
        rd_addr <= org_s ? {1'b0, rd_addr[6:0] + 7'd1} : rd_addr + 8'd1;
      end else begin
        rd_bit <= rd_bit + 4'd1;
      end
    end
  end

  assign sdo_oe = cs_s && (rd_active || stat);
  assign sdo    = stat ? ~busy : rd_q;

  AST_HIZ_CS_LOW:    assert property (@(posedge clk) disable iff (!rst_n) !$past(cs, 2) |-> !sdo_oe);        // R9
  AST_PROG_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(wel));       // R6
  AST_PROG_AT_CSFALL: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(cs_fall));   // R7
  AST_BUSY_READS_0:  assert property (@(posedge clk) disable iff (!rst_n) (busy && sdo_oe) |-> !sdo);         // R7
  AST_BUSY_WEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) busy |=> $stable(wel));             // R10
  AST_BUSY_NO_READ:  assert property (@(posedge clk) disable iff (!rst_n) busy |-> !rd_active);               // R10
  AST_READ_MARKER:   assert property (@(posedge clk) disable iff (!rst_n) $rose(rd_active) |-> !rd_q);        // R5
endmodule

// File: tb/tb_mw_eeprom.sv
module tb_mw_eeprom;
  localparam int PROG = 400;
  localparam int HP = 6;

  logic clk = 0, rst_n = 0, cs = 0, sclk = 0, sdi = 0, org16 = 0;
  logic sdo, sdo_oe;
  int total = 0, bad = 0;
  logic [7:0] mdl [256];

  mw_eeprom #(.PROG_CYCLES(PROG)) dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .sdi(sdi),
    .org16(org16), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  always #4 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic clk_bit(input logic b, output logic so, output logic soe);
    sdi = b;
    tick(HP);
    sclk = 1;
    tick(HP);
    so = sdo;
    soe = sdo_oe;
    sclk = 0;
  endtask

  task automatic shift_out(input logic [31:0] v, input int n, output logic so, output logic soe);
    so = 0; soe = 0;
    for (int i = n - 1; i >= 0; i--) clk_bit(v[i], so, soe);
  endtask

  task automatic cs_on();
    cs = 1;
    tick(3);
  endtask

  task automatic cs_off();
    sdi = 0;
    tick(2);
    cs = 0;
    tick(6);
  endtask

  task automatic cmd(input bit o16, input logic [1:0] op, input logic [8:0] fld,
                     input logic [15:0] d, input bit wd, input int delta, output logic lsoe);
    int af, w, n;
    logic [31:0] v;
    logic so;
    af = o16 ? 8 : 9;
    w = o16 ? 16 : 8;
    v = 32'd1;
    v = (v << 2) | 32'(op);
    v = (v << af) | 32'(fld);
    n = 3 + af;
    if (wd) begin
      v = (v << w) | (o16 ? 32'(d) : 32'(d[7:0]));
      n += w;
    end
    if (delta < 0) v = v >> (-delta);
    else v = v << delta;
    n += delta;
    org16 = o16;
    tick(3);
    cs_on();
    shift_out(v, n, so, lsoe);
    cs_off();
  endtask

  task automatic ext(input bit o16, input logic [1:0] sub, input logic [15:0] d, input bit wd, output logic lsoe);
    logic [8:0] f;
    f = o16 ? (9'(sub) << 6) : (9'(sub) << 7);
    cmd(o16, 2'b00, f, d, wd, 0, lsoe);
  endtask

  task automatic prog_ok(input string tag, input bit timed);
    int n;
    cs = 1;
    tick(4);
    chk(sdo_oe === 1'b1 && sdo === 1'b0, {tag, " busy status"}, {sdo_oe, sdo}, 2'b10);
    n = 0;
    while (sdo !== 1'b1 && n < PROG + 50) begin
      tick(1);
      n++;
    end
    chk(sdo === 1'b1 && sdo_oe === 1'b1, {tag, " ready status"}, {sdo_oe, sdo}, 2'b11);
    if (timed) chk(n >= PROG - 30 && n <= PROG, {tag, " busy length"}, n, PROG - 10);
    cs = 0;
    tick(6);
  endtask

  task automatic noprog(input string tag);
    cs = 1;
    tick(4);
    chk(sdo_oe === 1'b0, {tag, " no program cycle"}, sdo_oe, 0);
    cs = 0;
    tick(6);
  endtask

  function automatic logic [15:0] wexp(input bit o16, input int a);
    return o16 ? {mdl[2 * a], mdl[2 * a + 1]} : {8'h00, mdl[a]};
  endfunction

  task automatic rd_chk(input bit o16, input int a0, input int nw, input int lead, input string tag);
    int af, w, a;
    logic [31:0] v;
    logic so, soe;
    logic [15:0] got;
    af = o16 ? 8 : 9;
    w = o16 ? 16 : 8;
    a = a0;
    org16 = o16;
    tick(3);
    cs_on();
    for (int i = 0; i < lead; i++) clk_bit(1'b0, so, soe);
    v = 32'd1;
    v = (v << 2) | 32'd2;
    v = (v << af) | 32'(a);
    shift_out(v, 3 + af, so, soe);
    chk(soe === 1'b1 && so === 1'b0, {tag, " R5 marker bit"}, {soe, so}, 2'b10);
    for (int k = 0; k < nw; k++) begin
      got = '0;
      for (int b = 0; b < w; b++) begin
        clk_bit(1'b0, so, soe);
        got = {got[14:0], so};
      end
      chk(got === wexp(o16, a), {tag, " read data"}, got, wexp(o16, a));
      a = (a + 1) & (o16 ? 127 : 255);
    end
    cs_off();
    chk(sdo_oe === 1'b0, {tag, " R9 hi-z after cs low"}, sdo_oe, 0);
  endtask

  task automatic t_reset();
    chk(sdo_oe === 1'b0, "R12 oe low after reset", sdo_oe, 0);
    rd_chk(0, 0, 2, 0, "R12 erased array");
  endtask

  task automatic t_locked();
    logic s;
    cmd(0, 2'b01, 9'd5, 16'h003C, 1, 0, s);
    noprog("R6 locked write");
    rd_chk(0, 5, 1, 0, "R6 locked write");
  endtask

  task automatic t_enable();
    logic s;
    ext(0, 2'b11, 16'h0, 0, s);
    chk(s === 1'b0, "R9 oe low during enable", s, 0);
    noprog("R9 enable");
  endtask

  task automatic t_write8();
    logic s;
    cmd(0, 2'b01, 9'd5, 16'h003C, 1, 0, s);
    prog_ok("R7 write", 1);
    mdl[5] = 8'h3C;
    rd_chk(0, 5, 1, 3, "R1 R8 leading zeros");
    cmd(0, 2'b01, 9'd255, 16'h00A5, 1, 0, s);
    prog_ok("R8 write top", 0);
    mdl[255] = 8'hA5;
    cmd(0, 2'b01, 9'd0, 16'h005A, 1, 0, s);
    prog_ok("R8 write zero", 0);
    mdl[0] = 8'h5A;
    rd_chk(0, 255, 3, 0, "R5 byte stream wrap");
  endtask

  task automatic t_word();
    logic s;
    cmd(1, 2'b01, 9'd3, 16'h1234, 1, 0, s);
    prog_ok("R3 word write", 0);
    mdl[6] = 8'h12;
    mdl[7] = 8'h34;
    rd_chk(1, 3, 1, 0, "R3 word read");
    rd_chk(0, 6, 2, 0, "R3 byte order");
  endtask

  task automatic t_counts();
    logic s;
    cmd(1, 2'b01, 9'd3, 16'hABCD, 1, -1, s);
    noprog("R4 short write");
    cmd(1, 2'b01, 9'd3, 16'hABCD, 1, 1, s);
    noprog("R4 long write");
    cmd(0, 2'b11, 9'd6, 16'h0, 0, 1, s);
    noprog("R4 long erase");
    rd_chk(1, 3, 1, 0, "R4 unchanged");
  endtask

  task automatic t_erase();
    logic s;
    cmd(0, 2'b11, 9'd6, 16'h0, 0, 0, s);
    prog_ok("R2 R8 erase", 0);
    mdl[6] = 8'hFF;
    rd_chk(1, 3, 1, 0, "R8 erase byte");
  endtask

  task automatic t_resync();
    logic so, soe;
    org16 = 0;
    tick(3);
    cs_on();
    shift_out(32'b110, 3, so, soe);
    cs_off();
    rd_chk(0, 5, 1, 0, "R11 resync");
  endtask

  task automatic t_all();
    logic s;
    ext(1, 2'b01, 16'hBEEF, 1, s);
    prog_ok("R2 R8 write-all", 0);
    for (int i = 0; i < 256; i++) mdl[i] = (i % 2 == 0) ? 8'hBE : 8'hEF;
    rd_chk(0, 254, 4, 0, "R8 write-all");
    ext(0, 2'b10, 16'h0, 0, s);
    prog_ok("R2 R8 erase-all", 0);
    for (int i = 0; i < 256; i++) mdl[i] = 8'hFF;
    rd_chk(1, 126, 3, 0, "R8 erase-all word wrap");
  endtask

  task automatic t_busy();
    logic s;
    cmd(0, 2'b01, 9'd10, 16'h0011, 1, 0, s);
    ext(0, 2'b00, 16'h0, 0, s);
    mdl[10] = 8'h11;
    prog_ok("R10 busy write", 0);
    cmd(0, 2'b01, 9'd11, 16'h0022, 1, 0, s);
    prog_ok("R10 latch kept", 0);
    mdl[11] = 8'h22;
    rd_chk(0, 10, 2, 0, "R10 data");
  endtask

  task automatic t_disable();
    logic s;
    ext(0, 2'b00, 16'h0, 0, s);
    chk(s === 1'b0, "R9 oe low during disable", s, 0);
    cmd(0, 2'b01, 9'd12, 16'h0077, 1, 0, s);
    noprog("R6 disabled write");
    rd_chk(0, 12, 1, 0, "R6 disabled write");
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) mdl[i] = 8'hFF;
    tick(5);
    rst_n = 1;
    tick(4);
    t_reset();
    t_locked();
    t_enable();
    t_write8();
    t_word();
    t_counts();
    t_erase();
    t_resync();
    t_all();
    t_busy();
    t_disable();
    finish_run();
  end
endmodule